// File: doc/BRIEF.md
# Periodic Loop Master with In-Band Overrun Flag

This block is the timing source of a fixed-rate control loop. A down-counter loaded from a programmable period produces one iteration tick per period while the block is told to run. Each tick sends a one-cycle pulse out on an external trigger line, so that neighbouring devices can be clocked by it. The tick also flips a single handoff bit that starts a communication engine.

On each change of that bit the engine performs one iteration. It streams a fixed number of outbound words to the host over a ready/valid channel, then accepts a fixed number of inbound words. When the last inbound word arrives it raises a level interrupt, and the host paces itself on that interrupt. Transfers never time out, so a slow host stalls the engine rather than building a backlog.

When a tick arrives while the previous iteration is still owed or in progress, that iteration is late. The late state travels in bit 0 of the first outbound word of the iteration. The flag is not held from one iteration to the next. A saturating counter of late ticks is also brought out for test.

Top module: `loop_master`

## Requirements
- R1: While `run_i` is high, a tick occurs in the first cycle of running and then every P cycles, where P is the value of `period_i` sampled at the previous tick (0 counts as 1). `trig_o` is high in exactly the cycle after each tick.
- R2: A new `period_i` value has no effect on the tick spacing in progress; it takes effect from the next tick.
- R3: Each iteration presents exactly N_OUT outbound words and then exactly N_IN inbound words, in that order. `tx_valid_o` and `rx_ready_o` are never high together.
- R4: The outbound word with index k (0-based) of the iteration with sequence number s (0 for the first iteration after reset) has bits [DATA_W-1:1] = s for k = 0. For k > 0 the word is {s[DATA_W-9:0], k[7:0]}.
- R5: Bit 0 of outbound word 0 is 1 when the tick that owes the iteration arrived while an earlier iteration was still unfinished or owed, and 0 otherwise. The flag is recomputed for each iteration.
- R6: An iteration owed by a late tick starts once the engine is idle. A tick arriving while one iteration is already owed is merged into it. Every owed iteration completes after `run_i` falls.
- R7: No transfer times out: while `tx_valid_o` is high and `tx_ready_i` is low, the next cycle keeps `tx_valid_o` high and `tx_data_o` unchanged.
- R8: `irq_o` goes high in the cycle after the last inbound word of an iteration is accepted. It stays high until a cycle with `irq_ack_i` high, and clears in the cycle after that. A completion in the same cycle as the acknowledge leaves it high.
- R9: `late_cnt_o` is 0 after reset and increases by one for every late tick, saturating at all ones.
- R10: The cycle after an inbound word is accepted, `in_valid_o` is high for one cycle with that word on `in_data_o` and its index on `in_idx_o`.
- R11: During reset, `trig_o`, `irq_o`, `tx_valid_o`, `rx_ready_o`, `in_valid_o` and `late_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Act as timing master and produce ticks |
| period_i | input | CNT_W | Iteration period in clock cycles |
| trig_o | output | 1 | One-cycle external trigger pulse per tick |
| irq_o | output | 1 | Level interrupt, one set per completed iteration |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge |
| tx_valid_o | output | 1 | Outbound word valid |
| tx_ready_i | input | 1 | Host accepts outbound word |
| tx_data_o | output | DATA_W | Outbound word |
| rx_valid_i | input | 1 | Inbound word valid |
| rx_ready_o | output | 1 | Engine accepts inbound word |
| rx_data_i | input | DATA_W | Inbound word |
| in_valid_o | output | 1 | Received word strobe |
| in_idx_o | output | IDX_W | Index of the received word within its iteration |
| in_data_o | output | DATA_W | Received word |
| late_cnt_o | output | LATE_W | Saturating count of late ticks |

## Verification
The bench builds the block with four outbound and three inbound words, 32-bit data and a 16-bit period. An iteration therefore lasts at least nine cycles. Periods from 0 up to about 60 make on-time iterations, single misses and merged multiple misses all reachable, as do the one-cycle and zero periods. Saturation of the 32-bit late counter cannot be reached in a short run, so it rests on a property.

// File: rtl/lm_pkg.sv
`timescale 1ns/1ps
// Shared types for the loop master.
// Assumes nothing beyond the standard language.
package lm_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_SEND = 2'd1,
        ENG_RECV = 2'd2
    } eng_state_t;
endpackage

// File: rtl/lm_timer.sv
`timescale 1ns/1ps
// Period counter producing one iteration tick per period.
// Assumes: period is sampled only at a tick; 0 behaves as 1; while not
// running the counter rests at zero so the first running cycle ticks.
module lm_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             tick_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    assign tick_o = run_i && (remain_q == '0);

    // Count down; reload from the period register at each tick boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            remain_q <= '0;
        end else if (tick_o) begin
            remain_q <= (period_i == '0) ? '0 : period_i - ONE;
        end else begin
            remain_q <= remain_q - ONE;
        end
    end
endmodule

// File: rtl/lm_handoff.sv
`timescale 1ns/1ps
// Turns ticks into trigger pulses and handoff toggles; decides lateness.
// Assumes: the engine copies the toggle into seen_i when it starts, and
// busy_i is high from then until the iteration completes. At most one
// iteration is owed; further late ticks merge into it.
module lm_handoff #(
    parameter int LATE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              busy_i,
    input  logic              seen_i,
    output logic              trig_o,
    output logic              tgl_o,
    output logic              tag_o,
    output logic [LATE_W-1:0] late_cnt_o
);
    localparam logic [LATE_W-1:0] ONE = LATE_W'(1);

    logic trig_q, tgl_q, tag_q, owed_q;
    logic [LATE_W-1:0] late_q;
    logic engaged;

    // Engine counts as engaged from the toggle until it returns to idle.
    assign engaged = busy_i || (tgl_q != seen_i);

    // External trigger: one cycle after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= tick_i;
    end

    // Toggle issue, owed-iteration tracking and late counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q  <= 1'b0;
            tag_q  <= 1'b0;
            owed_q <= 1'b0;
            late_q <= '0;
        end else if (tick_i) begin
            if (!engaged && !owed_q) begin
                tgl_q <= ~tgl_q;
                tag_q <= 1'b0;
            end else begin
                owed_q <= 1'b1;
                if (late_q != '1) late_q <= late_q + ONE;
                if (!engaged) begin
                    tgl_q <= ~tgl_q;
                    tag_q <= 1'b1;
                end
            end
        end else if (owed_q && !engaged) begin
            tgl_q  <= ~tgl_q;
            tag_q  <= 1'b1;
            owed_q <= 1'b0;
        end
    end

    assign trig_o     = trig_q;
    assign tgl_o      = tgl_q;
    assign tag_o      = tag_q;
    assign late_cnt_o = late_q;
endmodule

// File: rtl/lm_comm.sv
`timescale 1ns/1ps
// Communication engine: one iteration per handoff toggle change.
// Sends N_OUT words, then receives N_IN words, then sets the interrupt.
// Assumes: N_OUT, N_IN >= 1, DATA_W > 8; transfers block without limit.
module lm_comm
    import lm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_OUT  = 4,
    parameter int N_IN   = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgl_i,
    input  logic              tag_i,
    output logic              seen_o,
    output logic              busy_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              in_valid_o,
    output logic [IDX_W-1:0]  in_idx_o,
    output logic [DATA_W-1:0] in_data_o,
    output logic              irq_o,
    input  logic              irq_ack_i
);
    localparam logic [IDX_W-1:0]  LAST_TX = IDX_W'(N_OUT - 1);
    localparam logic [IDX_W-1:0]  LAST_RX = IDX_W'(N_IN - 1);
    localparam logic [IDX_W-1:0]  IDX_ONE = IDX_W'(1);
    localparam logic [DATA_W-2:0] SEQ_ONE = (DATA_W-1)'(1);

    eng_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-2:0] seq_q;
    logic              seen_q, late_q, irq_q;
    logic              in_v_q;
    logic [IDX_W-1:0]  in_idx_q;
    logic [DATA_W-1:0] in_data_q;
    logic [7:0]        idx8;
    logic              rx_hs, done;

    assign idx8       = 8'(idx_q);
    assign tx_valid_o = (state_q == ENG_SEND);
    assign rx_ready_o = (state_q == ENG_RECV);
    assign busy_o     = (state_q != ENG_IDLE);
    assign seen_o     = seen_q;
    assign tx_data_o  = (idx_q == '0) ? {seq_q, late_q}
                                      : {seq_q[DATA_W-9:0], idx8};
    assign rx_hs      = rx_ready_o && rx_valid_i;
    assign done       = rx_hs && (idx_q == LAST_RX);

    // Iteration sequencer: start on toggle change, send, receive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            idx_q   <= '0;
            seq_q   <= '0;
            seen_q  <= 1'b0;
            late_q  <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: if (tgl_i != seen_q) begin
                    seen_q  <= tgl_i;
                    late_q  <= tag_i;
                    idx_q   <= '0;
                    state_q <= ENG_SEND;
                end
                ENG_SEND: if (tx_ready_i) begin
                    if (idx_q == LAST_TX) begin
                        idx_q   <= '0;
                        state_q <= ENG_RECV;
                    end else begin
                        idx_q <= idx_q + IDX_ONE;
                    end
                end
                ENG_RECV: if (rx_valid_i) begin
                    if (done) begin
                        idx_q   <= '0;
                        seq_q   <= seq_q + SEQ_ONE;
                        state_q <= ENG_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_ONE;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // Interrupt level: set on completion, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (done)      irq_q <= 1'b1;
        else if (irq_ack_i) irq_q <= 1'b0;
    end

    // Forward each accepted inbound word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_v_q    <= 1'b0;
            in_idx_q  <= '0;
            in_data_q <= '0;
        end else begin
            in_v_q <= rx_hs;
            if (rx_hs) begin
                in_idx_q  <= idx_q;
                in_data_q <= rx_data_i;
            end
        end
    end

    assign irq_o      = irq_q;
    assign in_valid_o = in_v_q;
    assign in_idx_o   = in_idx_q;
    assign in_data_o  = in_data_q;
endmodule

// File: rtl/loop_master.sv
`timescale 1ns/1ps
// Periodic loop master: timer, handoff/late logic and communication engine.
// Assumes: N_OUT, N_IN >= 1 and DATA_W > 8; synchronous active-low reset.
module loop_master #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int N_OUT  = 4,
    parameter int N_IN   = 3,
    parameter int LATE_W = 32,
    localparam int MAX_N = (N_OUT > N_IN) ? N_OUT : N_IN,
    localparam int IDX_W = $clog2(MAX_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  period_i,
    output logic              trig_o,
    output logic              irq_o,
    input  logic              irq_ack_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              in_valid_o,
    output logic [IDX_W-1:0]  in_idx_o,
    output logic [DATA_W-1:0] in_data_o,
    output logic [LATE_W-1:0] late_cnt_o
);
    logic tick, busy, seen, tgl, tag;

    lm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .period_i(period_i), .tick_o(tick)
    );

    lm_handoff #(.LATE_W(LATE_W)) u_handoff (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .busy_i(busy),
        .seen_i(seen), .trig_o(trig_o), .tgl_o(tgl), .tag_o(tag),
        .late_cnt_o(late_cnt_o)
    );

    lm_comm #(.DATA_W(DATA_W), .N_OUT(N_OUT), .N_IN(N_IN), .IDX_W(IDX_W)) u_comm (
        .clk(clk), .rst_n(rst_n), .tgl_i(tgl), .tag_i(tag),
        .seen_o(seen), .busy_o(busy),
        .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
        .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
        .in_valid_o(in_valid_o), .in_idx_o(in_idx_o), .in_data_o(in_data_o),
        .irq_o(irq_o), .irq_ack_i(irq_ack_i)
    );
endmodule

// File: rtl/lm_checker.sv
`timescale 1ns/1ps
// Protocol properties for the loop master, attached by bind.
// Assumes: observes top-level ports only.
module lm_checker #(
    parameter int DATA_W = 32,
    parameter int LATE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_i,
    input logic              trig_o,
    input logic              irq_o,
    input logic              irq_ack_i,
    input logic              tx_valid_o,
    input logic              tx_ready_i,
    input logic [DATA_W-1:0] tx_data_o,
    input logic              rx_valid_i,
    input logic              rx_ready_o,
    input logic [DATA_W-1:0] rx_data_i,
    input logic              in_valid_o,
    input logic [DATA_W-1:0] in_data_o,
    input logic [LATE_W-1:0] late_cnt_o
);
    p_trig_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(run_i));

    p_dir_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid_o && rx_ready_o));

    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_ack_i) |=> irq_o);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_ack_i && !(rx_valid_i && rx_ready_o)) |=> !irq_o);

    p_cnt_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (late_cnt_o >= $past(late_cnt_o)));

    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&late_cnt_o) |=> (&late_cnt_o));

    p_in_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_ready_o) |=> (in_valid_o && in_data_o == $past(rx_data_i)));
endmodule

bind loop_master lm_checker #(.DATA_W(DATA_W), .LATE_W(LATE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .trig_o(trig_o),
    .irq_o(irq_o), .irq_ack_i(irq_ack_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
    .in_valid_o(in_valid_o), .in_data_o(in_data_o), .late_cnt_o(late_cnt_o)
);

// File: tb/sim_loop_master.sv
`timescale 1ns/1ps
// Self-checking bench: random handshakes and periods plus directed cases,
// compared cycle by cycle against a requirement-level model.
module sim_loop_master;
    localparam int DW = 32, CW = 16, NO = 4, NI = 3, LW = 32;
    localparam int IW = $clog2(((NO > NI) ? NO : NI) + 1);

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
    logic [CW-1:0] period = '0;
    logic ack = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic trig, irq, tx_valid, rx_ready, in_valid;
    logic [DW-1:0] tx_data, in_data;
    logic [IW-1:0] in_idx;
    logic [LW-1:0] late_cnt;

    always #4 clk = ~clk;

    loop_master #(.DATA_W(DW), .CNT_W(CW), .N_OUT(NO), .N_IN(NI), .LATE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run), .period_i(period),
        .trig_o(trig), .irq_o(irq), .irq_ack_i(ack),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
        .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
        .in_valid_o(in_valid), .in_idx_o(in_idx), .in_data_o(in_data),
        .late_cnt_o(late_cnt)
    );

    int total = 0, fails = 0;
    bit finished = 1'b0;

    // Stimulus knobs
    int p_ready = 100, p_valid = 100, p_ack = 50;
    bit stall = 1'b0;

    // Model state
    int  mcnt = 0, mout = 0, mtx = 0, mrx = 0, qh = 0, qt = 0;
    bit  q [4];
    bit  exp_trig = 1'b0, mirq = 1'b0, exp_inv = 1'b0, prev_stall = 1'b0;
    logic [DW-1:0] exp_in_data = '0, prev_data = '0;
    int  exp_in_idx = 0;
    logic [31:0] mseq = '0;
    logic [LW-1:0] mlate = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_word(input int k, input logic [31:0] s, input bit late);
        if (k == 0) return {s[DW-2:0], late};
        return {s[DW-9:0], 8'(k)};
    endfunction

    // One cycle at a negedge: check outputs, drive inputs, advance the model.
    task automatic cyc();
        bit tick, txhs, rxhs, done;
        logic [DW-1:0] ew;
        chk(trig == exp_trig, "R1 R2", "trigger", trig, exp_trig);
        chk(irq == mirq, "R8", "irq", irq, mirq);
        chk(late_cnt == mlate, "R9", "late count", late_cnt, mlate);
        chk(in_valid == exp_inv, "R10", "in_valid", in_valid, exp_inv);
        if (exp_inv) begin
            chk(in_data == exp_in_data, "R10", "in_data", in_data, exp_in_data);
            chk(int'(in_idx) == exp_in_idx, "R10", "in_idx", in_idx, exp_in_idx);
        end
        if (prev_stall)
            chk(tx_valid && tx_data == prev_data, "R7", "held word", tx_data, prev_data);
        if (tx_valid)
            chk(!rx_ready && mtx < NO && mrx == 0, "R3", "send phase tx count", mtx, NO);
        if (rx_ready)
            chk(!tx_valid && mtx == NO, "R3", "receive phase tx count", mtx, NO);

        tx_ready = !stall && (($urandom % 100) < p_ready);
        rx_valid = !stall && (($urandom % 100) < p_valid);
        rx_data  = $urandom;
        ack      = ($urandom % 100) < p_ack;

        tick = run && (mcnt == 0);
        if (!run) mcnt = 0;
        else if (tick) mcnt = (period == 0) ? 0 : int'(period) - 1;
        else mcnt--;
        exp_trig = tick;

        txhs = tx_valid && tx_ready;
        if (txhs) begin
            ew = exp_word(mtx, mseq, (mtx == 0) ? q[qh % 4] : 1'b0);
            if (mtx == 0) begin
                chk(tx_data[0] == ew[0], "R5", "late bit", tx_data[0], ew[0]);
                qh++;
            end
            chk(tx_data[DW-1:1] == ew[DW-1:1], "R4", "word", tx_data, ew);
            mtx++;
        end
        rxhs = rx_ready && rx_valid;
        done = 1'b0;
        if (rxhs) begin
            exp_in_data = rx_data;
            exp_in_idx  = mrx;
            done = (mrx == NI - 1);
            mrx++;
        end
        exp_inv = rxhs;

        if (tick) begin
            if (mout == 0) begin
                mout = 1; q[qt % 4] = 1'b0; qt++;
            end else begin
                if (mout == 1) begin mout = 2; q[qt % 4] = 1'b1; qt++; end
                if (mlate != '1) mlate = mlate + 1'b1;
            end
        end
        if (done) begin
            mout--; mseq++; mtx = 0; mrx = 0; mirq = 1'b1;
        end else if (ack) begin
            mirq = 1'b0;
        end
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
        @(negedge clk);
    endtask

    task automatic run_for(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!trig && !irq && !tx_valid && !rx_ready && !in_valid && late_cnt == '0,
            "R11", "reset outputs", {trig, irq, tx_valid, rx_ready, in_valid}, 0);
        rst_n = 1'b1;

        // Directed: comfortable period, free-flowing host, no lateness.
        period = 40; run = 1'b1;
        run_for(600);
        chk(late_cnt == '0, "R5", "on-time count", late_cnt, 0);

        // Directed: long outbound stall forces late and merged ticks (R6, R7).
        period = 30;
        run_for(50);
        stall = 1'b1; run_for(120); stall = 1'b0;
        run_for(300);
        chk(late_cnt != '0, "R6", "late ticks seen", late_cnt, 1);

        // Directed: period shorter than one iteration, continuous lateness.
        period = 6;
        run_for(200);

        // Directed: period change mid-count takes effect at the next tick (R2).
        period = 50; run_for(70);
        period = 11; run_for(100);

        // Random mix of periods and handshake rates.
        for (int blk = 0; blk < 15; blk++) begin
            period  = CW'(5 + ($urandom % 56));
            p_ready = 30 + ($urandom % 71);
            p_valid = 30 + ($urandom % 71);
            p_ack   = 5 + ($urandom % 90);
            if (($urandom % 4) == 0) begin
                run_for(40); stall = 1'b1; run_for(30 + ($urandom % 60)); stall = 1'b0;
            end
            run_for(200);
        end

        // Corner periods: one and zero behave alike.
        p_ready = 100; p_valid = 100;
        period = 1; run_for(50);
        period = 0; run_for(50);
        period = 2; run_for(50);

        // Stop and drain: every owed iteration completes (R6).
        run = 1'b0; p_ack = 100;
        run_for(200);
        chk(mout == 0 && !tx_valid && !rx_ready, "R6", "drained",
            {tx_valid, rx_ready}, 0);
        chk(mtx == 0 && mrx == 0, "R3", "counts at rest", mtx + mrx, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule